// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block performs interrupt entry for a small 32-bit processor core. Each cycle it looks at three kinds of request: a reset request, a non-maskable interrupt (NMI), and six maskable interrupt lines. It also sees the core's current program counter and status word. When it accepts a request, it does the following on a single clock edge:

- it loads a new program counter (the fixed vector for that source) and a new status word;
- it saves the interrupted program counter and status word into the backup pair that belongs to that kind of request;
- it rewrites the relevant half of the cause register;
- it raises a one-cycle redirect strobe that tells the core to fetch from the new program counter.

An NMI that arrives while an earlier NMI is still being handled is held in a one-deep pending flag. The core pulses a return-from-NMI strobe when it leaves the NMI handler, and the held NMI is then taken.

All pins are plain control and status signals sampled on every clock. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. The core must apply `new_pc` and `new_psw` in the cycle in which `redirect` is high. The status word bits used are:

| Bit | Meaning |
|-----|---------|
| 5 | interrupt disable |
| 6 | exception in progress |
| 7 | NMI in progress |

Top module: `irq_entry_ctrl`

## Requirements
- R1: Every accepted entry raises `redirect` high for exactly the cycle after the request is sampled, and `new_pc`/`new_psw` change on that same edge. The new status word has bit 5 set and bit 6 cleared.
- R2: A sampled `reset_req` gives `new_pc` = 0, `new_psw` = 0x20 and `cause` = 0, and clears the pending NMI flag.
- R3: An NMI is taken when bit 7 of the effective status word is clear. `fepc` receives `cur_pc`. `fepsw` receives the status word with bit 5 set and bit 6 cleared. `new_psw` is that same value with bit 7 also set. `new_pc` = 0x10.
- R4: On an NMI entry, `cause` becomes its old lower 16 bits with 0x10 ORed in, and its upper 16 bits become zero.
- R5: On a maskable entry, `eipc` receives `cur_pc` and `eipsw` receives the status word with bit 5 set and bit 6 cleared (`new_psw` equals `eipsw`). `cause` keeps its upper 16 bits, and its lower 16 bits become the vector value.
- R6: Maskable line i (bit i of `mask_req`, i = 0..5) vectors to 0x80 + 0x10*i. When several lines are high, the lowest index wins.
- R7: Priority is reset first, then NMI, then the maskable lines.
- R8: Maskable requests are ignored while bit 5 of `cur_psw` is set: no redirect occurs and the outputs hold.
- R9: An NMI that arrives while bit 7 of `cur_psw` is set (and `nmi_ret` is low) is not taken. It sets the pending flag instead. Any number of such NMIs produce only one later entry.
- R10: If `nmi_ret` is high while the pending flag is set, bit 7 of `cur_psw` is treated as clear. The held NMI is taken with `redirect` high in the next cycle, `fepsw` shows bit 7 clear, and the pending flag is cleared.
- R11: After `rst_n` is released, `new_pc` = 0, `new_psw` = 0x20, and all other outputs are 0. With no accepted request, every output holds its value and `redirect` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | Program counter of the interrupted instruction stream |
| cur_psw | input | 32 | Current status word |
| reset_req | input | 1 | Reset entry request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| mask_req | input | 6 | Maskable interrupt lines, bit 0 has highest priority |
| nmi_ret | input | 1 | Return-from-NMI strobe |
| new_pc | output | 32 | Program counter to fetch from after a redirect |
| new_psw | output | 32 | Status word to install after a redirect |
| redirect | output | 1 | One-cycle strobe marking an entry |
| fepc | output | 32 | Saved program counter for NMI |
| fepsw | output | 32 | Saved status word for NMI |
| eipc | output | 32 | Saved program counter for maskable interrupts |
| eipsw | output | 32 | Saved status word for maskable interrupts |
| cause | output | 32 | Cause register: NMI half and maskable half |

## Verification
The hardest case to reach from the ports is the held NMI, for two reasons. It needs an NMI to arrive while the status word shows NMI in progress. It then needs a return strobe some cycles later, with further NMIs arriving in between that must not be counted. The stimulus first holds bit 7 of `cur_psw` high and pulses `nmi_req` several times. It then asserts `nmi_ret` once and checks for exactly one redirect to 0x10 in the following cycle. Long random runs then mix return strobes, NMIs and status words against the reference model, so that pending, reset and maskable requests collide in the same cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ENT_NONE  = 2'd0,
    ENT_RESET = 2'd1,
    ENT_NMI   = 2'd2,
    ENT_MASK  = 2'd3
  } entry_kind_e;
endpackage

// File: rtl/irq_arb.sv
module irq_arb
  import irq_entry_pkg::*;
#(
  parameter int N_MASK = 6,
  localparam int IDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1
) (
  input  logic              reset_req,
  input  logic              nmi_want,
  input  logic              np_eff,
  input  logic              id_set,
  input  logic [N_MASK-1:0] mask_req,
  output entry_kind_e       kind,
  output logic [IDX_W-1:0]  src_idx,
  output logic              nmi_blocked
);
  logic mask_hit;

  // lowest index wins: scan downward so the last match is the smallest
  always_comb begin
    src_idx = '0;
    for (int i = N_MASK - 1; i >= 0; i--) begin
      if (mask_req[i]) src_idx = IDX_W'(i);
    end
  end

  assign mask_hit    = (|mask_req) && !id_set;
  assign nmi_blocked = nmi_want && np_eff && !reset_req;

  always_comb begin
    if (reset_req)               kind = ENT_RESET;
    else if (nmi_want && !np_eff) kind = ENT_NMI;
    else if (mask_hit)           kind = ENT_MASK;
    else                         kind = ENT_NONE;
  end
endmodule

// File: rtl/irq_nmi_hold.sv
module irq_nmi_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (clr_i) pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
  end
endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
  import irq_entry_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          N_MASK    = 6,
  parameter int          ID_BIT    = 5,
  parameter int          EP_BIT    = 6,
  parameter int          NP_BIT    = 7,
  parameter logic [31:0] RESET_PSW = 32'h20,
  parameter logic [31:0] NMI_VEC   = 32'h10,
  parameter logic [31:0] VEC_BASE  = 32'h80,
  parameter logic [31:0] VEC_STEP  = 32'h10,
  localparam int IDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1,
  localparam int HALF  = XLEN / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  entry_kind_e      kind,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  psw_eff,
  output logic [XLEN-1:0]  new_pc,
  output logic [XLEN-1:0]  new_psw,
  output logic             redirect,
  output logic [XLEN-1:0]  fepc,
  output logic [XLEN-1:0]  fepsw,
  output logic [XLEN-1:0]  eipc,
  output logic [XLEN-1:0]  eipsw,
  output logic [XLEN-1:0]  cause
);
  logic [XLEN-1:0] vec_tab [N_MASK];
  logic [XLEN-1:0] entry_psw;
  logic [XLEN-1:0] mask_vec;

  for (genvar g = 0; g < N_MASK; g++) begin : g_vec
    assign vec_tab[g] = XLEN'(VEC_BASE + VEC_STEP * g);
  end

  assign mask_vec = vec_tab[src_idx];

  always_comb begin
    entry_psw         = psw_eff;
    entry_psw[ID_BIT] = 1'b1;
    entry_psw[EP_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_pc   <= '0;
      new_psw  <= XLEN'(RESET_PSW);
      redirect <= 1'b0;
      fepc     <= '0;
      fepsw    <= '0;
      eipc     <= '0;
      eipsw    <= '0;
      cause    <= '0;
    end else begin
      redirect <= (kind != ENT_NONE);
      unique case (kind)
        ENT_RESET: begin
          new_pc  <= '0;
          new_psw <= XLEN'(RESET_PSW);
          cause   <= '0;
        end
        ENT_NMI: begin
          fepc            <= cur_pc;
          fepsw           <= entry_psw;
          new_psw         <= entry_psw | (XLEN'(1) << NP_BIT);
          new_pc          <= XLEN'(NMI_VEC);
          cause           <= {{(XLEN-HALF){1'b0}}, cause[HALF-1:0]} | XLEN'(NMI_VEC);
        end
        ENT_MASK: begin
          eipc    <= cur_pc;
          eipsw   <= entry_psw;
          new_psw <= entry_psw;
          new_pc  <= mask_vec;
          cause   <= {cause[XLEN-1:HALF], {HALF{1'b0}}} | mask_vec;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          N_MASK    = 6,
  parameter int          ID_BIT    = 5,
  parameter int          EP_BIT    = 6,
  parameter int          NP_BIT    = 7,
  parameter logic [31:0] RESET_PSW = 32'h20,
  parameter logic [31:0] NMI_VEC   = 32'h10,
  parameter logic [31:0] VEC_BASE  = 32'h80,
  parameter logic [31:0] VEC_STEP  = 32'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_psw,
  input  logic              reset_req,
  input  logic              nmi_req,
  input  logic [N_MASK-1:0] mask_req,
  input  logic              nmi_ret,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_psw,
  output logic              redirect,
  output logic [XLEN-1:0]   fepc,
  output logic [XLEN-1:0]   fepsw,
  output logic [XLEN-1:0]   eipc,
  output logic [XLEN-1:0]   eipsw,
  output logic [XLEN-1:0]   cause
);
  localparam int IDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1;

  entry_kind_e      kind;
  logic [IDX_W-1:0] src_idx;
  logic             nmi_blocked;
  logic             nmi_pend;
  logic [XLEN-1:0]  psw_eff;

  // a return strobe frees the NMI slot in the same cycle
  always_comb begin
    psw_eff = cur_psw;
    if (nmi_ret) psw_eff[NP_BIT] = 1'b0;
  end

  irq_arb #(.N_MASK(N_MASK)) u_arb (
    .reset_req   (reset_req),
    .nmi_want    (nmi_req | nmi_pend),
    .np_eff      (psw_eff[NP_BIT]),
    .id_set      (cur_psw[ID_BIT]),
    .mask_req    (mask_req),
    .kind        (kind),
    .src_idx     (src_idx),
    .nmi_blocked (nmi_blocked)
  );

  irq_nmi_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (nmi_blocked),
    .clr_i  ((kind == ENT_RESET) || (kind == ENT_NMI)),
    .pend_o (nmi_pend)
  );

  irq_entry_regs #(
    .XLEN(XLEN), .N_MASK(N_MASK), .ID_BIT(ID_BIT), .EP_BIT(EP_BIT),
    .NP_BIT(NP_BIT), .RESET_PSW(RESET_PSW), .NMI_VEC(NMI_VEC),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .src_idx  (src_idx),
    .cur_pc   (cur_pc),
    .psw_eff  (psw_eff),
    .new_pc   (new_pc),
    .new_psw  (new_psw),
    .redirect (redirect),
    .fepc     (fepc),
    .fepsw    (fepsw),
    .eipc     (eipc),
    .eipsw    (eipsw),
    .cause    (cause)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int          XLEN      = 32,
  parameter int          N_MASK    = 6,
  parameter int          ID_BIT    = 5,
  parameter int          EP_BIT    = 6,
  parameter int          NP_BIT    = 7,
  parameter logic [31:0] RESET_PSW = 32'h20,
  parameter logic [31:0] NMI_VEC   = 32'h10,
  parameter logic [31:0] VEC_BASE  = 32'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   cur_pc,
  input logic [XLEN-1:0]   cur_psw,
  input logic              reset_req,
  input logic              nmi_req,
  input logic [N_MASK-1:0] mask_req,
  input logic              nmi_ret,
  input logic              nmi_pend,
  input logic [XLEN-1:0]   new_pc,
  input logic [XLEN-1:0]   new_psw,
  input logic              redirect,
  input logic [XLEN-1:0]   fepc,
  input logic [XLEN-1:0]   eipsw,
  input logic [XLEN-1:0]   cause
);
  localparam int HALF = XLEN / 2;

  // R1
  entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (new_psw[ID_BIT] && !new_psw[EP_BIT]));

  // R2
  reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (redirect && new_pc == '0 && new_psw == XLEN'(RESET_PSW)
                   && cause == '0 && !nmi_pend));

  // R3
  nmi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && (nmi_req || nmi_pend) && !(cur_psw[NP_BIT] && !nmi_ret))
    |=> (redirect && new_pc == XLEN'(NMI_VEC) && new_psw[NP_BIT]
         && fepc == $past(cur_pc)));

  // R9
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && nmi_req && cur_psw[NP_BIT] && !nmi_ret)
    |=> (nmi_pend && new_pc != XLEN'(NMI_VEC) || nmi_pend && !redirect));

  // R8
  mask_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !nmi_req && !nmi_pend && cur_psw[ID_BIT]) |=> !redirect);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !nmi_req && !nmi_pend && mask_req == '0)
    |=> (!redirect && $stable(new_pc) && $stable(cause)));

  // R5
  mask_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && new_pc >= XLEN'(VEC_BASE))
    |-> (cause[HALF-1:0] == new_pc[HALF-1:0] && eipsw == new_psw));
endmodule

bind irq_entry_ctrl irq_entry_chk #(
  .XLEN(XLEN), .N_MASK(N_MASK), .ID_BIT(ID_BIT), .EP_BIT(EP_BIT),
  .NP_BIT(NP_BIT), .RESET_PSW(RESET_PSW), .NMI_VEC(NMI_VEC), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_psw(cur_psw),
  .reset_req(reset_req), .nmi_req(nmi_req), .mask_req(mask_req),
  .nmi_ret(nmi_ret), .nmi_pend(nmi_pend), .new_pc(new_pc),
  .new_psw(new_psw), .redirect(redirect), .fepc(fepc), .eipsw(eipsw),
  .cause(cause)
);

// File: tb/sim_irq_entry_ctrl.sv
`timescale 1ns/1ps
module sim_irq_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0, cur_psw = '0;
  logic        reset_req = 1'b0, nmi_req = 1'b0, nmi_ret = 1'b0;
  logic [5:0]  mask_req = '0;
  logic [31:0] new_pc, new_psw, fepc, fepsw, eipc, eipsw, cause;
  logic        redirect;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_psw(cur_psw),
    .reset_req(reset_req), .nmi_req(nmi_req), .mask_req(mask_req),
    .nmi_ret(nmi_ret), .new_pc(new_pc), .new_psw(new_psw),
    .redirect(redirect), .fepc(fepc), .fepsw(fepsw), .eipc(eipc),
    .eipsw(eipsw), .cause(cause)
  );

  // behavioural reference model
  logic [31:0] m_pc = 0, m_psw = 32'h20, m_fepc = 0, m_fepsw = 0;
  logic [31:0] m_eipc = 0, m_eipsw = 0, m_cause = 0;
  logic        m_redir = 0;
  bit          m_pend = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_psw = 32'h20; m_fepc = 0; m_fepsw = 0;
      m_eipc = 0; m_eipsw = 0; m_cause = 0; m_redir = 0; m_pend = 0;
    end else begin
      logic [31:0] pe, ent;
      pe = cur_psw;
      if (nmi_ret) pe[7] = 1'b0;
      ent = (pe | 32'h20) & ~32'h40;
      m_redir = 0;
      if (reset_req) begin
        m_pc = 0; m_psw = 32'h20; m_cause = 0; m_pend = 0; m_redir = 1;
      end else if ((nmi_req || m_pend) && !pe[7]) begin
        m_fepc = cur_pc; m_fepsw = ent; m_psw = ent | 32'h80; m_pc = 32'h10;
        m_cause = (m_cause & 32'h0000ffff) | 32'h10; m_pend = 0; m_redir = 1;
      end else begin
        if (nmi_req || m_pend) m_pend = 1;
        if (mask_req != 0 && !cur_psw[5]) begin
          int k;
          k = 0;
          while (!mask_req[k]) k++;
          m_eipc = cur_pc; m_eipsw = ent; m_psw = ent;
          m_pc = 32'h80 + 32'h10 * k;
          m_cause = (m_cause & 32'hffff0000) | m_pc; m_redir = 1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R1/R2/R3/R5/R6 new_pc", new_pc, m_pc);
    chk("R1/R3/R5 new_psw", new_psw, m_psw);
    chk("R1/R11 redirect", {31'b0, redirect}, {31'b0, m_redir});
    chk("R3/R10 fepc", fepc, m_fepc);
    chk("R3/R10 fepsw", fepsw, m_fepsw);
    chk("R5 eipc", eipc, m_eipc);
    chk("R5 eipsw", eipsw, m_eipsw);
    chk("R4/R5 cause", cause, m_cause);
  end

  task automatic idle();
    reset_req = 0; nmi_req = 0; nmi_ret = 0; mask_req = '0;
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R11 reset state
    chk("R11 reset pc", new_pc, 32'h0);
    chk("R11 reset psw", new_psw, 32'h20);
    chk("R11 reset redirect", {31'b0, redirect}, 32'h0);

    // R6 every maskable vector, status word clear
    for (int i = 0; i < 6; i++) begin
      cur_pc = 32'h1000 + i; cur_psw = 32'h41; mask_req = 6'(1 << i);
      cyc(1);
      idle();
      chk("R6 vector", new_pc, 32'h80 + 32'h10 * i);
      chk("R5 eipc", eipc, 32'h1000 + i);
      chk("R5 eipsw", eipsw, 32'h21);
      chk("R1 pulse", {31'b0, redirect}, 32'h1);
      cyc(1);
      chk("R1 pulse ends", {31'b0, redirect}, 32'h0);
    end

    // R6 lowest index wins
    cur_psw = 0; mask_req = 6'b101100; cyc(1); idle();
    chk("R6 lowest wins", new_pc, 32'hA0);
    cyc(1);

    // R8 masked while disable bit set
    cur_psw = 32'h20; mask_req = 6'h3f; cyc(1); idle();
    chk("R8 ignored", {31'b0, redirect}, 32'h0);
    chk("R8 pc held", new_pc, 32'hA0);
    cyc(1);

    // R3/R4 NMI taken
    cur_pc = 32'h2000; cur_psw = 32'h41; nmi_req = 1; cyc(1); idle();
    chk("R3 nmi pc", new_pc, 32'h10);
    chk("R3 fepc", fepc, 32'h2000);
    chk("R3 fepsw", fepsw, 32'h21);
    chk("R3 new_psw", new_psw, 32'hA1);
    chk("R4 cause", cause, 32'hB0);
    cyc(1);

    // R7 priority
    cur_psw = 0; nmi_req = 1; mask_req = 6'h01; cyc(1); idle();
    chk("R7 nmi over mask", new_pc, 32'h10);
    cyc(1);
    cur_pc = 32'h3000; reset_req = 1; nmi_req = 1; mask_req = 6'h3f; cyc(1); idle();
    chk("R7/R2 reset first", new_pc, 32'h0);
    chk("R2 reset psw", new_psw, 32'h20);
    chk("R2 reset cause", cause, 32'h0);
    cyc(1);

    // R9 held NMI, several arrivals, then R10 release
    cur_pc = 32'h4000; cur_psw = 32'hA0;
    for (int i = 0; i < 3; i++) begin
      nmi_req = 1; cyc(1); nmi_req = 0;
      chk("R9 not taken", {31'b0, redirect}, 32'h0);
      cyc(1);
    end
    nmi_ret = 1; cur_pc = 32'h4400; cyc(1); nmi_ret = 0;
    chk("R10 taken next cycle", {31'b0, redirect}, 32'h1);
    chk("R10 vector", new_pc, 32'h10);
    chk("R10 fepsw np clear", fepsw, 32'h20);
    chk("R10 fepc", fepc, 32'h4400);
    cur_psw = 32'h0;
    cyc(1);
    chk("R9 single entry", {31'b0, redirect}, 32'h0);
    cyc(2);
    chk("R9 no second entry", {31'b0, redirect}, 32'h0);

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      cur_pc    = $urandom;
      cur_psw   = $urandom & 32'hffff_ff1f | (($urandom % 8) << 5);
      reset_req = ($urandom % 40) == 0;
      nmi_req   = ($urandom % 6) == 0;
      nmi_ret   = ($urandom % 8) == 0;
      mask_req  = (($urandom % 3) == 0) ? 6'($urandom) : 6'h0;
      cyc(1);
    end
    idle();
    cyc(2);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule